// File: doc/BRIEF.md
# Procedure Return Sequencer

This block executes the four return-from-procedure opcodes of a 32-bit segmented processor. It takes an opcode byte, an optional 16-bit release count, the current privilege level and a protected-mode flag. It then pops the return words from the stack through a single-word read port. From those words it updates the instruction pointer, the code selector, the stack pointer, the stack selector and the four data-segment selectors. It ends each return with a one-cycle done pulse.

There are three kinds of return. A near return pops only the instruction pointer. A far return also pops a code selector. A far return to an outer (numerically higher) privilege level in protected mode also pops a new stack pointer and stack selector. On that last path it zeroes each data-segment selector whose accessibility flag is low. The release count adds extra bytes to the stack pointer once the return address is off the stack.

The command and memory-request sides use valid/ready handshakes. A command is taken only when `op_valid` and `op_ready` are both high at a clock edge. `op_ready` is high exactly when the sequencer is idle, so a caller holds its command until it sees ready. The read request obeys normal back-pressure: once raised, `rd_req_valid` and `rd_addr` stay put until `rd_req_ready` is seen. Exactly one read is outstanding at a time. Its response comes back on `rd_rsp_valid` at least one cycle after the request is taken. The response path has no ready signal.

Top module: `proc_return_seq`

## Requirements
- R1: Opcodes are decoded as follows: 0xC3 is a near return and 0xC2 a near return with release count; 0xCB is a far return and 0xCA a far return with release count. For 0xC3 and 0xCB the `op_imm` value is ignored and the release count is zero.
- R2: A near return loads `ip` with the 32-bit word read at the starting `sp`. `sp` ends at its start value + 4 + release count, and `cs_sel` is unchanged.
- R3: A far return reads the `ip` word at `sp`, then the code-selector word at `sp`+4, and loads `cs_sel` with that word's low 16 bits. Without a privilege change, `sp` ends at start + 8 + release count, `ss_sel` is unchanged, and `new_pl` equals `cur_pl`.
- R4: A far return is privilege-changing when `prot_en` is high and bits [1:0] of the popped code selector exceed `cur_pl`. It then reads a new stack pointer at start + 8 + release count and a stack-selector word at start + 12 + release count. `sp` becomes the popped value + release count, `ss_sel` becomes the low 16 bits of the second word, and `new_pl` becomes the popped selector's bits [1:0].
- R5: On a privilege-changing return only, each data-segment selector is zeroed when its `seg_ok` bit is 0 (bit 0 DS, 1 ES, 2 FS, 3 GS). `seg_ok` is sampled at the edge that takes the stack-selector word. On every other return the data-segment selectors are unchanged.
- R6: Any other opcode raises `illegal_op` for exactly the cycle after the command is taken. It changes no register and issues no memory read.
- R7: `op_ready` is high only when idle. `busy` is high from the cycle after a legal command is taken until the cycle before `done`. `done` is a one-cycle pulse with `busy` low.
- R8: A read request keeps `rd_req_valid` high and `rd_addr` stable until `rd_req_ready` is seen, and a new request follows only after the previous response.
- R9: `ld_en` loads `ip`, `cs_sel`, `sp`, `ss_sel` and the data-segment selectors (`ld_dsel` bits [15:0] DS, [31:16] ES, [47:32] FS, [63:48] GS). It does so only in a cycle where the sequencer is idle and `op_valid` is low; otherwise it has no effect.
- R10: A synchronous active-low reset makes the sequencer idle and clears every architectural register, `new_pl`, `done` and `illegal_op` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command valid |
| op_ready | output | 1 | Command accepted when high with op_valid (idle) |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 16 | Release count in bytes |
| cur_pl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected mode active |
| seg_ok | input | 4 | Data-segment accessibility at the new level |
| busy | output | 1 | Return in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal_op | output | 1 | One-cycle unsupported-opcode pulse |
| new_pl | output | 2 | Privilege level after the last return |
| rd_req_valid | output | 1 | Stack read request valid |
| rd_req_ready | input | 1 | Stack read request taken |
| rd_addr | output | 32 | Stack read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| ld_en | input | 1 | Register preload strobe |
| ld_ip | input | 32 | Preload instruction pointer |
| ld_cs | input | 16 | Preload code selector |
| ld_sp | input | 32 | Preload stack pointer |
| ld_ss | input | 16 | Preload stack selector |
| ld_dsel | input | 64 | Preload data-segment selectors |
| ip | output | 32 | Instruction pointer |
| cs_sel | output | 16 | Code selector |
| sp | output | 32 | Stack pointer |
| ss_sel | output | 16 | Stack selector |
| ds_sel | output | 16 | DS selector |
| es_sel | output | 16 | ES selector |
| fs_sel | output | 16 | FS selector |
| gs_sel | output | 16 | GS selector |

## Verification
`illegal_op` is due one cycle after the command edge, and `busy` is already high at that point for a legal opcode. `done` and the final register values appear one cycle after the edge that takes the last response word. The number of cycles before that depends on read-ready stalls and a response latency that alternates between one and two cycles. The bench therefore samples every output at the falling edge. It checks the command-edge results at the first falling edge after acceptance, and it waits on `done` before comparing the register file. It then confirms at the following falling edge that `done` has dropped.

// File: rtl/pret_pkg.sv
package pret_pkg;
  localparam logic [7:0] OPC_NEAR     = 8'hC3;
  localparam logic [7:0] OPC_NEAR_IMM = 8'hC2;
  localparam logic [7:0] OPC_FAR      = 8'hCB;
  localparam logic [7:0] OPC_FAR_IMM  = 8'hCA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IP,
    ST_CS,
    ST_SP,
    ST_SS
  } seq_st_e;

  typedef struct packed {
    logic legal;
    logic far;
    logic has_imm;
  } ret_dec_t;
endpackage

// File: rtl/pret_decode.sv
module pret_decode
  import pret_pkg::*;
(
  input  logic [7:0] code,
  output ret_dec_t   dec
);
  always_comb begin
    dec = '0;
    unique case (code)
      OPC_NEAR:     dec = '{legal: 1'b1, far: 1'b0, has_imm: 1'b0};
      OPC_NEAR_IMM: dec = '{legal: 1'b1, far: 1'b0, has_imm: 1'b1};
      OPC_FAR:      dec = '{legal: 1'b1, far: 1'b1, has_imm: 1'b0};
      OPC_FAR_IMM:  dec = '{legal: 1'b1, far: 1'b1, has_imm: 1'b1};
      default:      dec = '0;
    endcase
  end
endmodule

// File: rtl/pret_popper.sv
module pret_popper #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] addr,
  output logic         rd_req_valid,
  input  logic         rd_req_ready,
  output logic [W-1:0] rd_addr,
  input  logic         rd_rsp_valid,
  output logic         word_ok
);
  // ph_q: 0 = request phase, 1 = awaiting the response
  logic ph_q;

  assign rd_req_valid = go && !ph_q;
  assign rd_addr      = addr;
  assign word_ok      = ph_q && rd_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else if (!ph_q) begin
      if (rd_req_valid && rd_req_ready) ph_q <= 1'b1;
    end else if (rd_rsp_valid) begin
      ph_q <= 1'b0;
    end
  end

  // R8: a stalled request holds valid and address
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
endmodule

// File: rtl/pret_segclr.sv
module pret_segclr #(
  parameter int NSEG = 4,
  parameter int SW   = 16
) (
  input  logic [NSEG-1:0][SW-1:0] sel_in,
  input  logic [NSEG-1:0]         ok,
  output logic [NSEG-1:0][SW-1:0] sel_out
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign sel_out[g] = ok[g] ? sel_in[g] : '0;
  end
endmodule

// File: rtl/proc_return_seq.sv
module proc_return_seq
  import pret_pkg::*;
#(
  parameter int W   = 32,
  parameter int SW  = 16,
  parameter int IW  = 16,
  parameter int PLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [7:0]     op_code,
  input  logic [IW-1:0]  op_imm,
  input  logic [PLW-1:0] cur_pl,
  input  logic           prot_en,
  input  logic [3:0]     seg_ok,
  output logic           busy,
  output logic           done,
  output logic           illegal_op,
  output logic [PLW-1:0] new_pl,
  output logic           rd_req_valid,
  input  logic           rd_req_ready,
  output logic [W-1:0]   rd_addr,
  input  logic           rd_rsp_valid,
  input  logic [W-1:0]   rd_rsp_data,
  input  logic           ld_en,
  input  logic [W-1:0]   ld_ip,
  input  logic [SW-1:0]  ld_cs,
  input  logic [W-1:0]   ld_sp,
  input  logic [SW-1:0]  ld_ss,
  input  logic [4*SW-1:0] ld_dsel,
  output logic [W-1:0]   ip,
  output logic [SW-1:0]  cs_sel,
  output logic [W-1:0]   sp,
  output logic [SW-1:0]  ss_sel,
  output logic [SW-1:0]  ds_sel,
  output logic [SW-1:0]  es_sel,
  output logic [SW-1:0]  fs_sel,
  output logic [SW-1:0]  gs_sel
);
  localparam int NSEG = 4;
  localparam logic [W-1:0] STEP = W'(W / 8);

  seq_st_e st_q;
  ret_dec_t dec;

  logic            far_q, prot_q, priv_q, done_q, ill_q;
  logic [IW-1:0]   imm_q;
  logic [PLW-1:0]  pl_q, newpl_q;
  logic [W-1:0]    ptr_q, spn_q, ip_q, sp_q;
  logic [SW-1:0]   cs_q, ss_q;
  logic [NSEG-1:0][SW-1:0] dsel_q, dsel_clr;
  logic            word_ok;
  logic [W-1:0]    immx;
  logic [PLW-1:0]  rpl;

  assign immx = W'(imm_q);
  assign rpl  = rd_rsp_data[PLW-1:0];

  pret_decode u_dec (
    .code (op_code),
    .dec  (dec)
  );

  pret_popper #(.W(W)) u_pop (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (st_q != ST_IDLE),
    .addr         (ptr_q),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .word_ok      (word_ok)
  );

  pret_segclr #(.NSEG(NSEG), .SW(SW)) u_seg (
    .sel_in  (dsel_q),
    .ok      (seg_ok),
    .sel_out (dsel_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      far_q   <= 1'b0;
      prot_q  <= 1'b0;
      priv_q  <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      imm_q   <= '0;
      pl_q    <= '0;
      newpl_q <= '0;
      ptr_q   <= '0;
      spn_q   <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      cs_q    <= '0;
      ss_q    <= '0;
      dsel_q  <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (op_valid) begin
            if (!dec.legal) begin
              ill_q <= 1'b1;
            end else begin
              far_q  <= dec.far;
              prot_q <= prot_en;
              priv_q <= 1'b0;
              imm_q  <= dec.has_imm ? op_imm : '0;
              pl_q   <= cur_pl;
              ptr_q  <= sp_q;
              st_q   <= ST_IP;
            end
          end else if (ld_en) begin
            ip_q   <= ld_ip;
            cs_q   <= ld_cs;
            sp_q   <= ld_sp;
            ss_q   <= ld_ss;
            dsel_q <= ld_dsel;
          end
        end
        ST_IP: begin
          if (word_ok) begin
            ip_q  <= rd_rsp_data;
            ptr_q <= ptr_q + STEP;
            if (!far_q) begin
              sp_q    <= ptr_q + STEP + immx;
              newpl_q <= pl_q;
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              st_q <= ST_CS;
            end
          end
        end
        ST_CS: begin
          if (word_ok) begin
            cs_q  <= rd_rsp_data[SW-1:0];
            ptr_q <= ptr_q + STEP + immx;
            if (prot_q && (rpl > pl_q)) begin
              priv_q  <= 1'b1;
              newpl_q <= rpl;
              st_q    <= ST_SP;
            end else begin
              sp_q    <= ptr_q + STEP + immx;
              newpl_q <= pl_q;
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        ST_SP: begin
          if (word_ok) begin
            spn_q <= rd_rsp_data;
            ptr_q <= ptr_q + STEP;
            st_q  <= ST_SS;
          end
        end
        ST_SS: begin
          if (word_ok) begin
            ss_q   <= rd_rsp_data[SW-1:0];
            sp_q   <= spn_q + immx;
            dsel_q <= dsel_clr;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_ready   = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign illegal_op = ill_q;
  assign new_pl     = newpl_q;
  assign ip         = ip_q;
  assign cs_sel     = cs_q;
  assign sp         = sp_q;
  assign ss_sel     = ss_q;
  assign ds_sel     = dsel_q[0];
  assign es_sel     = dsel_q[1];
  assign fs_sel     = dsel_q[2];
  assign gs_sel     = dsel_q[3];

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: an unsupported opcode leaves the register file untouched
  a_r6_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> $stable(ip_q) && $stable(sp_q) && $stable(cs_q) && $stable(ss_q));
  // R6: no stack read follows an unsupported opcode
  a_r6_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !rd_req_valid);
  // R2: a near return keeps the code selector
  a_r2_near_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done && !far_q |-> $stable(cs_q));
  // R5: an inaccessible DS is zeroed on the privilege-changing path
  a_r5_ds_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done && priv_q && !$past(seg_ok[0]) |-> ds_sel == '0);
  // R5: data selectors stay put otherwise
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    done && !priv_q |-> $stable(dsel_q));
  // R4: the privilege level only moves outward
  a_r4_outward: assert property (@(posedge clk) disable iff (!rst_n)
    done && priv_q |-> new_pl > pl_q);
endmodule

// File: tb/proc_return_seq_tb_top.sv
module proc_return_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        op_valid = 1'b0, op_ready;
  logic [7:0]  op_code = '0;
  logic [15:0] op_imm = '0;
  logic [1:0]  cur_pl = '0;
  logic        prot_en = 1'b0;
  logic [3:0]  seg_ok = '0;
  logic        busy, done, illegal_op;
  logic [1:0]  new_pl;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_addr, rd_rsp_data;
  logic        ld_en = 1'b0;
  logic [31:0] ld_ip = '0, ld_sp = '0;
  logic [15:0] ld_cs = '0, ld_ss = '0;
  logic [63:0] ld_dsel = '0;
  logic [31:0] ip, sp;
  logic [15:0] cs_sel, ss_sel, ds_sel, es_sel, fs_sel, gs_sel;

  proc_return_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_imm(op_imm), .cur_pl(cur_pl), .prot_en(prot_en),
    .seg_ok(seg_ok), .busy(busy), .done(done), .illegal_op(illegal_op),
    .new_pl(new_pl), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .ld_en(ld_en), .ld_ip(ld_ip), .ld_cs(ld_cs), .ld_sp(ld_sp), .ld_ss(ld_ss),
    .ld_dsel(ld_dsel), .ip(ip), .cs_sel(cs_sel), .sp(sp), .ss_sel(ss_sel),
    .ds_sel(ds_sel), .es_sel(es_sel), .fs_sel(fs_sel), .gs_sel(gs_sel)
  );

  // stack memory model: stalls on ready, latency alternates 1 / 2
  logic [31:0] mem [0:255];
  logic [31:0] paddr = '0;
  int          lat = 0;
  bit          alt = 1'b0;
  int          cyc = 0;
  int          reads = 0;
  initial begin
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
  end
  always @(posedge clk) begin
    cyc          <= cyc + 1;
    rd_req_ready <= (cyc % 3) != 0;
    rd_rsp_valid <= 1'b0;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[paddr[9:2]];
      end
    end
    if (rd_req_valid && rd_req_ready) begin
      paddr <= rd_addr;
      lat   <= alt ? 2 : 1;
      alt   <= ~alt;
      reads <= reads + 1;
    end
  end

  int tests = 0;
  int fails = 0;
  int idx = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [15:0] imm, input logic [1:0] cpl,
                        input logic pe, input logic [3:0] ok, input logic [1:0] rpl,
                        input bit poke);
    logic [31:0] base, w0, w1, w2, w3, ip0, sp0, eimm;
    logic [15:0] cs0, ss0;
    logic [15:0] d0 [4];
    logic [15:0] ed [4];
    bit legal, far, hasimm, priv;
    int startreads, wait_n;
    idx++;
    base = 32'h100 + 32'((idx % 8) * 32);
    ip0 = 32'h0000_5500 + 32'(idx);
    cs0 = 16'h0008 + 16'(idx);
    ss0 = 16'h0010 + 16'(idx);
    for (int i = 0; i < 4; i++) d0[i] = 16'h0018 + 16'(i * 8) + 16'(idx * 64);
    sp0 = base;
    legal  = (opc == 8'hC3) || (opc == 8'hC2) || (opc == 8'hCB) || (opc == 8'hCA);
    far    = (opc == 8'hCB) || (opc == 8'hCA);
    hasimm = (opc == 8'hC2) || (opc == 8'hCA);
    eimm   = hasimm ? 32'(imm) : 32'h0;
    priv   = legal && far && pe && (rpl > cpl);
    w0 = 32'h1000_0000 + 32'(idx);
    w1 = {16'hABCD, 5'b0, 8'(idx), 1'b0, rpl};
    w2 = 32'h0000_2000 + 32'(idx * 16);
    w3 = {16'hEEEE, 16'h0040 + 16'(idx)};
    mem[base[9:2]]               = w0;
    mem[base[9:2] + 8'd1]        = w1;
    mem[8'((base + 8 + eimm) >> 2)]     = w2;
    mem[8'(((base + 8 + eimm) >> 2) + 1)] = w3;

    // preload the register file while idle
    @(negedge clk);
    ld_en = 1'b1; ld_ip = ip0; ld_cs = cs0; ld_sp = sp0; ld_ss = ss0;
    ld_dsel = {d0[3], d0[2], d0[1], d0[0]};
    @(negedge clk);
    ld_en = 1'b0;
    chk("R9 preload sp", sp, sp0);
    op_valid = 1'b1; op_code = opc; op_imm = imm; cur_pl = cpl; prot_en = pe; seg_ok = ok;
    startreads = reads;
    chk("R7 ready when idle", 32'(op_ready), 32'd1);
    @(negedge clk);
    op_valid = 1'b0;
    op_code = 8'h00;
    if (!legal) begin
      chk("R6 illegal pulse", 32'(illegal_op), 32'd1);
      chk("R6 not busy", 32'(busy), 32'd0);
      chk("R6 ip kept", ip, ip0);
      chk("R6 sp kept", sp, sp0);
      @(negedge clk);
      chk("R6 pulse ends", 32'(illegal_op), 32'd0);
      chk("R6 no reads", 32'(reads - startreads), 32'd0);
      chk("R6 cs kept", 32'(cs_sel), 32'(cs0));
      return;
    end
    chk("R7 busy after accept", 32'(busy), 32'd1);
    chk("R7 not ready while busy", 32'(op_ready), 32'd0);
    if (poke) begin
      ld_en = 1'b1; ld_ip = 32'hDEAD_BEEF; ld_sp = 32'h0BAD_0000; ld_cs = 16'hFFFF;
      ld_ss = 16'hFFFF; ld_dsel = '1;
      @(negedge clk);
      ld_en = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R7 done seen", 32'(done), 32'd1);
    chk("R7 busy low at done", 32'(busy), 32'd0);
    chk("R2 ip loaded", ip, w0);
    if (!far) begin
      chk("R2 near sp", sp, sp0 + 4 + eimm);
      chk("R2 near cs kept", 32'(cs_sel), 32'(cs0));
      chk("R1 near pl", 32'(new_pl), 32'(cpl));
    end else begin
      chk("R3 far cs", 32'(cs_sel), 32'(w1[15:0]));
    end
    if (far && !priv) begin
      chk("R3 far sp", sp, sp0 + 8 + eimm);
      chk("R3 ss kept", 32'(ss_sel), 32'(ss0));
      chk("R3 pl kept", 32'(new_pl), 32'(cpl));
    end
    if (priv) begin
      chk("R4 new sp", sp, w2 + eimm);
      chk("R4 new ss", 32'(ss_sel), 32'(w3[15:0]));
      chk("R4 new pl", 32'(new_pl), 32'(rpl));
      chk("R4 four reads", 32'(reads - startreads), 32'd4);
    end
    for (int i = 0; i < 4; i++) ed[i] = (priv && !ok[i]) ? 16'h0 : d0[i];
    chk("R5 ds", 32'(ds_sel), 32'(ed[0]));
    chk("R5 es", 32'(es_sel), 32'(ed[1]));
    chk("R5 fs", 32'(fs_sel), 32'(ed[2]));
    chk("R5 gs", 32'(gs_sel), 32'(ed[3]));
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] opcs [4];
    opcs[0] = 8'hC3; opcs[1] = 8'hC2; opcs[2] = 8'hCB; opcs[3] = 8'hCA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ip zero", ip, 32'h0);
    chk("R10 sp zero", sp, 32'h0);
    chk("R10 cs zero", 32'(cs_sel), 32'h0);
    chk("R10 ds zero", 32'(ds_sel), 32'h0);
    chk("R10 idle", 32'(busy), 32'h0);
    chk("R10 no done", 32'(done), 32'h0);
    chk("R10 no illegal", 32'(illegal_op), 32'h0);
    chk("R10 ready", 32'(op_ready), 32'h1);
    // R6 sweep of every unsupported opcode
    for (int o = 0; o < 256; o++) begin
      if (o != 8'hC3 && o != 8'hC2 && o != 8'hCB && o != 8'hCA)
        run_op(8'(o), 16'h0004, 2'd0, 1'b1, 4'hF, 2'd3, 1'b0);
    end
    // R1..R5, R7..R9 sweep over opcode, levels, mode and flags
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int p = 0; p < 2; p++)
            run_op(opcs[k], 16'(4 * ((r + c) % 4)), 2'(c), p[0],
                   4'(c * 5 + r * 3 + p), 2'(r), (r == c));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule